// File: doc/BRIEF.md
# Synchronization Flywheel Counter

This block decides when a block-synchronized serial data decoder has lost lock. Once the upstream detector reports sync, each completed block arrives as a one-cycle strobe with a flag that marks it as uncorrectable or valid. Uncorrectable blocks raise an up/down error counter and valid blocks lower it. When an error block would push the count past a programmable 6-bit limit, the block emits a single-cycle loss pulse, and the synchronizer upstream then restarts its search.

Two limit codes select special modes. A limit of 0 turns the flywheel off, so the count stays at zero and no loss is ever raised. A limit of 63 (all ones) makes the flywheel endless: the count saturates and never produces a loss, so sync is held until something outside restarts it. After reset the limit is 32.

Top module: `sync_flywheel`

## Requirements
- R1: After reset `count_o` is 0, `loss_o` is 0 and the limit is 32.
- R2: When a block strobe with `blk_err_i`=1 is sampled while counting is active and no overflow occurs, `count_o` rises by one at that edge.
- R3: When a block strobe with `blk_err_i`=0 is sampled while counting is active, `count_o` falls by one at that edge and stays at 0 if it was 0.
- R4: Counting is active only when `sync_i` was sampled high at this edge and at the previous edge. At any other edge `count_o` is cleared to 0 and block strobes are ignored.
- R5: An error block sampled with count >= limit, while the limit is neither 0 nor 63, is an overflow. At that edge `loss_o` goes high for exactly one clock and `count_o` returns to 0.
- R6: A `lim_wr_i` pulse loads `lim_data_i` as the limit. A block sampled at the same edge still uses the old limit.
- R7: With limit 0, `count_o` is held at 0 and `loss_o` never rises.
- R8: With limit 63, `count_o` saturates at 63 and `loss_o` never rises.
- R9: While counting is active, an edge with no block strobe leaves `count_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Decoder is synchronized |
| blk_done_i | input | 1 | One-cycle strobe: a block has been processed |
| blk_err_i | input | 1 | The strobed block is uncorrectable |
| lim_wr_i | input | 1 | Load strobe for the limit |
| lim_data_i | input | 6 | New limit value |
| loss_o | output | 1 | One-cycle loss-of-sync pulse |
| count_o | output | 6 | Current error-block count |

## Verification
The bench goes after the edges of the count range. It decrements at 0, where a design without saturation would wrap to 63. It raises the count at 63 under the endless limit, where a wrong design would either wrap or report a loss. It runs limit 1, which overflows on the second error, so an off-by-one in the compare moves the loss pulse by a block. It also checks that the count clears on the first edge of a new sync and that a block sampled together with a limit write still uses the old limit; a design that gets these wrong keeps stale counts or shifts the loss timing. Random block streams mixed with sync drops and writes of the limits 0, 1, 32 and 63 confirm that the pulse lasts exactly one clock and lands on the predicted edge.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [1:0] {
    FW_OFF     = 2'd0,
    FW_NORMAL  = 2'd1,
    FW_ENDLESS = 2'd2
  } fw_mode_e;
endpackage

// File: rtl/fw_limit_reg.sv
module fw_limit_reg #(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned LIM_RST = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [CNT_W-1:0]     data_i,
  output logic [CNT_W-1:0]     lim_o,
  output fw_pkg::fw_mode_e     mode_o
);
  localparam logic [CNT_W-1:0] LIM_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lim_q <= CNT_W'(LIM_RST);
    else if (wr_i) lim_q <= data_i;
  end

  always_comb begin
    if (lim_q == '0)          mode_o = fw_pkg::FW_OFF;
    else if (lim_q == LIM_MAX) mode_o = fw_pkg::FW_ENDLESS;
    else                       mode_o = fw_pkg::FW_NORMAL;
  end

  assign lim_o = lim_q;
endmodule

// File: rtl/fw_sync_gate.sv
module fw_sync_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic active_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  // first synced edge clears, counting starts on the next one
  assign active_o = sync_i & sync_q;
endmodule

// File: rtl/fw_loss_detect.sv
module fw_loss_detect #(
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic                 done_i,
  input  logic                 err_i,
  input  fw_pkg::fw_mode_e     mode_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CNT_W-1:0]     lim_i,
  output logic                 ovf_o,
  output logic                 loss_o
);
  logic loss_q;

  assign ovf_o = active_i & done_i & err_i &
                 (mode_i == fw_pkg::FW_NORMAL) & (cnt_i >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) loss_q <= 1'b0;
    else         loss_q <= ovf_o;
  end

  assign loss_o = loss_q;
endmodule

// File: rtl/fw_counter.sv
module fw_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic                 done_i,
  input  logic                 err_i,
  input  logic                 ovf_i,
  input  fw_pkg::fw_mode_e     mode_i,
  output logic [CNT_W-1:0]     cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!active_i || mode_i == fw_pkg::FW_OFF || ovf_i) begin
      cnt_d = '0;
    end else if (done_i) begin
      if (err_i) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sync_flywheel.sv
module sync_flywheel #(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned LIM_RST = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             blk_done_i,
  input  logic             blk_err_i,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_data_i,
  output logic             loss_o,
  output logic [CNT_W-1:0] count_o
);
  logic             active;
  logic             ovf;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt;
  fw_pkg::fw_mode_e mode;

  fw_limit_reg #(.CNT_W(CNT_W), .LIM_RST(LIM_RST)) u_lim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (lim_wr_i),
    .data_i (lim_data_i),
    .lim_o  (lim_q),
    .mode_o (mode)
  );

  fw_sync_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .active_o (active)
  );

  fw_loss_detect #(.CNT_W(CNT_W)) u_loss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .done_i   (blk_done_i),
    .err_i    (blk_err_i),
    .mode_i   (mode),
    .cnt_i    (cnt),
    .lim_i    (lim_q),
    .ovf_o    (ovf),
    .loss_o   (loss_o)
  );

  fw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .done_i   (blk_done_i),
    .err_i    (blk_err_i),
    .ovf_i    (ovf),
    .mode_i   (mode),
    .cnt_o    (cnt)
  );

  assign count_o = cnt;
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             blk_done_i,
  input logic             blk_err_i,
  input logic             loss_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] lim_q
);
  localparam logic [CNT_W-1:0] LIM_MAX = {CNT_W{1'b1}};

  logic sync_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_prev <= 1'b0;
    else         sync_prev <= sync_i;
  end

  logic act;
  assign act = sync_i & sync_prev;

  assert_err_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && blk_done_i && blk_err_i && lim_q != '0 && lim_q != LIM_MAX && count_o < lim_q)
    |=> count_o == $past(count_o) + 1'b1);

  assert_valid_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && blk_done_i && !blk_err_i && lim_q != '0)
    |=> count_o == (($past(count_o) == '0) ? '0 : $past(count_o) - 1'b1));

  assert_nosync_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> (count_o == '0 && !loss_o));

  assert_loss_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_o |=> !loss_o);

  assert_loss_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_o |-> count_o == '0);

  assert_off_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_q == '0) |=> (count_o == '0 && !loss_o));

  assert_endless_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_q == LIM_MAX) |=> !loss_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !blk_done_i && lim_q != '0) |=> $stable(count_o));
endmodule

bind sync_flywheel fw_checker #(.CNT_W(CNT_W)) u_fw_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_i     (sync_i),
  .blk_done_i (blk_done_i),
  .blk_err_i  (blk_err_i),
  .loss_o     (loss_o),
  .count_o    (count_o),
  .lim_q      (lim_q)
);

// File: tb/sync_flywheel_test.sv
`timescale 1ns/1ps
module sync_flywheel_test;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, done = 1'b0, err = 1'b0, wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic loss;
  logic [W-1:0] cnt;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  int m_lim, m_cnt, m_loss;
  bit m_sync_q;

  always #10 clk = ~clk;

  sync_flywheel #(.CNT_W(W), .LIM_RST(32)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_i     (sync),
    .blk_done_i (done),
    .blk_err_i  (err),
    .lim_wr_i   (wr),
    .lim_data_i (wdata),
    .loss_o     (loss),
    .count_o    (cnt)
  );

  function automatic void model_step(bit s, bit d, bit e, bit w, int wd);
    m_loss = 0;
    if (!(s && m_sync_q) || m_lim == 0) m_cnt = 0;
    else if (d) begin
      if (e) begin
        if (m_lim != 63 && m_cnt >= m_lim) begin m_cnt = 0; m_loss = 1; end
        else if (m_cnt != 63) m_cnt++;
      end else if (m_cnt != 0) m_cnt--;
    end
    if (w) m_lim = wd;
    m_sync_q = s;
  endfunction

  task automatic check(string tag);
    checks++;
    if (int'(cnt) != m_cnt || int'(loss) != m_loss) begin
      fails++;
      $display("FAIL %s: count=%0d loss=%0d expected count=%0d loss=%0d",
               tag, cnt, loss, m_cnt, m_loss);
    end
  endtask

  // called at a negedge; applies inputs for one edge and checks at the next negedge
  task automatic cyc(bit s, bit d, bit e, bit w, int wd, string tag);
    sync = s; done = d; err = e; wr = w; wdata = W'(wd);
    @(posedge clk);
    model_step(s, d, e, w, wd);
    @(negedge clk);
    check(tag);
  endtask

  task automatic set_lim(int v, string tag);
    cyc(sync, 1'b0, 1'b0, 1'b1, v, tag);
  endtask

  task automatic acquire(string tag);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, tag);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_lim = 32; m_cnt = 0; m_loss = 0; m_sync_q = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state");

    // default limit 32: 33rd error overflows (R1, R5)
    acquire("R4 acquire");
    for (int i = 0; i < 32; i++) cyc(1, 1, 1, 0, 0, "R2 count up to default limit");
    if (cnt != 32) begin fails++; $display("FAIL R1: count=%0d expected=32", cnt); end
    checks++;
    cyc(1, 1, 1, 0, 0, "R1 R5 overflow at default limit 32");
    cyc(1, 0, 0, 0, 0, "R5 pulse one clock");

    // decrement saturating at 0
    cyc(1, 1, 1, 0, 0, "R2 inc");
    cyc(1, 1, 0, 0, 0, "R3 dec");
    cyc(1, 1, 0, 0, 0, "R3 saturate at zero");
    cyc(1, 0, 0, 0, 0, "R9 idle hold");

    // limit 1
    set_lim(1, "R6 write limit 1");
    cyc(1, 1, 1, 0, 0, "R2 limit1 first error");
    cyc(1, 0, 0, 0, 0, "R9 hold");
    cyc(1, 1, 1, 0, 0, "R5 limit1 overflow");
    cyc(1, 1, 1, 0, 0, "R5 restart after loss");

    // block sampled with a write uses old limit
    cyc(1, 1, 1, 1, 0, "R6 old limit applies at write edge");
    cyc(1, 1, 1, 0, 0, "R7 limit 0 holds zero");
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 0, "R7 no loss with limit 0");

    // limit 63 endless
    set_lim(63, "R6 write limit 63");
    for (int i = 0; i < 70; i++) cyc(1, 1, 1, 0, 0, "R8 endless saturate");
    if (cnt != 63) begin fails++; $display("FAIL R8: count=%0d expected=63", cnt); end
    checks++;
    cyc(1, 1, 0, 0, 0, "R3 dec from 63");

    // sync drop and reacquire
    cyc(0, 1, 1, 0, 0, "R4 sync low clears");
    cyc(0, 1, 1, 0, 0, "R4 blocks ignored unsynced");
    cyc(1, 1, 1, 0, 0, "R4 first synced edge ignores block");
    cyc(1, 1, 1, 0, 0, "R4 counting resumes");

    // limit reduced below count
    set_lim(32, "R6 write 32");
    for (int i = 0; i < 10; i++) cyc(1, 1, 1, 0, 0, "R2 inc");
    set_lim(4, "R6 write below count");
    cyc(1, 1, 1, 0, 0, "R5 overflow when count above limit");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit s = (r < 97) ? 1'b1 : 1'b0;
      bit d = $urandom_range(0, 2) != 0;
      bit e = $urandom_range(0, 99) < 55;
      bit w = $urandom_range(0, 99) < 2;
      int pick = $urandom_range(0, 4);
      int wd = (pick == 0) ? 0 : (pick == 1) ? 1 : (pick == 2) ? 32 :
               (pick == 3) ? 63 : $urandom_range(2, 8);
      cyc(s, d, e, w, wd, "R2 R3 R5 random stream");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule